// File: doc/BRIEF.md
# UART Host Register Bank

This block is the processor-facing register file of a 16550-compatible UART. A 3-bit address, a read strobe and a write strobe select one of twelve logical registers. The same address can name different registers for reads and for writes. The top bit of the line control register is a divisor-access bit. When it is set, the two lowest addresses lead to the baud divisor bytes instead of the data holding path and the interrupt enable register.

The block holds the control state: interrupt enable, line control, modem control, the divisor, the FIFO settings and a scratchpad. It returns the line status, modem status and interrupt status words that neighbouring logic supplies. Accesses to the data holding address become single-cycle push and pop strobes toward the transmit and receive paths. Writes to the FIFO control address become single-cycle clear strobes for the two FIFOs. Read data is selected from the current decode and captured on the clock edge that samples the read strobe.

Top module: `uart_regbank`

## Requirements
- R1: After reset, `lcr`, `ier`, `mcr`, `div_lo`, `div_hi`, `fifo_en`, `rx_trig`, `rdata` and all strobe outputs are zero. With `irq_pend` low, a read of address 2 returns 0x01.
- R2: With `lcr[7]` clear, reads return the following:
  - address 0: `rx_data`
  - address 1: interrupt enable
  - address 2: interrupt status
  - address 3: line control
  - address 4: modem control
  - address 5: `lsr_in`
  - address 6: `msr_in`
  - address 7: scratchpad
- R3: With `lcr[7]` set, address 0 reads and writes `div_lo` and address 1 reads and writes `div_hi`. These accesses leave the interrupt enable register unchanged and raise neither `tx_push` nor `rx_pop`.
- R4: A write to address 0 with `lcr[7]` clear raises `tx_push` for exactly the following cycle, with `tx_data` equal to the written byte.
- R5: A read of address 0 with `lcr[7]` clear raises `rx_pop` for exactly the following cycle, and `rdata` returns `rx_data`.
- R6: A write to address 2 sets `fifo_en` from bit 0 and `rx_trig` from bits 7:6. It pulses `rx_fifo_clr` for one cycle if bit 1 is 1 and `tx_fifo_clr` for one cycle if bit 2 is 1. A read of address 2 never returns this value.
- R7: The interrupt status word is {fifo_en, fifo_en, 2'b00, irq_id[2:0], ~irq_pend}.
- R8: Writes to addresses 5 and 6 change no register and raise no strobe.
- R9: Line control at address 3 and the scratchpad at address 7 read and write the same way whatever the value of `lcr[7]`.
- R10: Interrupt enable keeps only bits 3:0 and modem control keeps only bits 4:0. Their other bits read as zero.
- R11: `rdata` changes only on a clock edge that samples `rd_en` high. Between reads it holds its value even when the status inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe, one access per cycle high |
| rd_en | input | 1 | Read strobe, one access per cycle high |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| tx_push | output | 1 | Transmit holding load strobe |
| tx_data | output | 8 | Byte that goes with `tx_push` |
| rx_pop | output | 1 | Receive holding unload strobe |
| rx_data | input | 8 | Head byte of the receive path |
| rx_fifo_clr | output | 1 | Receive FIFO clear strobe |
| tx_fifo_clr | output | 1 | Transmit FIFO clear strobe |
| fifo_en | output | 1 | FIFO enable setting |
| rx_trig | output | 2 | Receive trigger level select |
| irq_pend | input | 1 | Interrupt pending from interrupt logic |
| irq_id | input | 3 | Interrupt identification code |
| lsr_in | input | 8 | Line status word |
| msr_in | input | 8 | Modem status word |
| ier | output | 4 | Interrupt enable bits |
| lcr | output | 8 | Line control register |
| mcr | output | 5 | Modem control bits |
| div_lo | output | 8 | Divisor low byte |
| div_hi | output | 8 | Divisor high byte |

## Verification
The bench sets the divisor-access bit and then writes addresses 0 and 1. A design that ignored that bit would raise a transmit push or overwrite interrupt enable. The bench reads address 2 after loading FIFO control, which catches a design that returns the written FIFO settings instead of the interrupt status. Writes to the two status addresses are followed by reads of every writable register, which exposes an address decode that leaks onto a neighbour. The bench also changes the status inputs between reads to catch read data that follows the mux instead of the strobe.

// File: rtl/uart_regbank.sv
module uart_regbank #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          tx_push,
  output logic [DW-1:0] tx_data,
  output logic          rx_pop,
  input  logic [DW-1:0] rx_data,
  output logic          rx_fifo_clr,
  output logic          tx_fifo_clr,
  output logic          fifo_en,
  output logic [1:0]    rx_trig,
  input  logic          irq_pend,
  input  logic [2:0]    irq_id,
  input  logic [DW-1:0] lsr_in,
  input  logic [DW-1:0] msr_in,
  output logic [3:0]    ier,
  output logic [DW-1:0] lcr,
  output logic [4:0]    mcr,
  output logic [DW-1:0] div_lo,
  output logic [DW-1:0] div_hi
);
  localparam logic [2:0] A_DATA = 3'd0, A_IER = 3'd1, A_IID = 3'd2, A_LCR = 3'd3;
  localparam logic [2:0] A_MCR  = 3'd4, A_LSR = 3'd5, A_MSR = 3'd6, A_SPR = 3'd7;

  logic [DW-1:0] spr;
  logic [DW-1:0] rd_mux;
  logic [DW-1:0] isr_word;
  logic          dlab;

  assign dlab     = lcr[DW-1];
  assign isr_word = DW'({fifo_en, fifo_en, 2'b00, irq_id, ~irq_pend});

  always_comb begin
    case (addr)
      A_DATA:  rd_mux = dlab ? div_lo : rx_data;
      A_IER:   rd_mux = dlab ? div_hi : DW'(ier);
      A_IID:   rd_mux = isr_word;
      A_LCR:   rd_mux = lcr;
      A_MCR:   rd_mux = DW'(mcr);
      A_LSR:   rd_mux = lsr_in;
      A_MSR:   rd_mux = msr_in;
      default: rd_mux = spr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rx_pop <= 1'b0;
    end else begin
      rx_pop <= rd_en && addr == A_DATA && !dlab;
      if (rd_en) rdata <= rd_mux;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_push     <= 1'b0;
      tx_data     <= '0;
      rx_fifo_clr <= 1'b0;
      tx_fifo_clr <= 1'b0;
      fifo_en     <= 1'b0;
      rx_trig     <= 2'b00;
      ier         <= '0;
      lcr         <= '0;
      mcr         <= '0;
      div_lo      <= '0;
      div_hi      <= '0;
      spr         <= '0;
    end else begin
      tx_push     <= 1'b0;
      rx_fifo_clr <= 1'b0;
      tx_fifo_clr <= 1'b0;
      if (wr_en) begin
        case (addr)
          A_DATA: begin
            if (dlab) div_lo <= wdata;
            else begin
              tx_push <= 1'b1;
              tx_data <= wdata;
            end
          end
          A_IER: begin
            if (dlab) div_hi <= wdata;
            else      ier    <= wdata[3:0];
          end
          A_IID: begin
            fifo_en     <= wdata[0];
            rx_trig     <= wdata[DW-1:DW-2];
            rx_fifo_clr <= wdata[1];
            tx_fifo_clr <= wdata[2];
          end
          A_LCR:   lcr <= wdata;
          A_MCR:   mcr <= wdata[4:0];
          A_SPR:   spr <= wdata;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    addr,
  input logic          wr_en,
  input logic          rd_en,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic          tx_push,
  input logic [DW-1:0] tx_data,
  input logic          rx_pop,
  input logic          rx_fifo_clr,
  input logic [DW-1:0] lcr,
  input logic [DW-1:0] div_lo
);
  a_r4_push_src: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> $past(wr_en && addr == 3'd0 && !lcr[DW-1]));
  a_r4_push_data: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> tx_data == $past(wdata));
  a_r5_pop_src: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> $past(rd_en && addr == 3'd0 && !lcr[DW-1]));
  a_r6_rxclr_src: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fifo_clr |-> $past(wr_en && addr == 3'd2 && wdata[1]));
  a_r9_lcr_load: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && addr == 3'd3) |-> lcr == $past(wdata));
  a_r3_div_lo_load: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && addr == 3'd0 && lcr[DW-1]) |-> (div_lo == $past(wdata)) && !tx_push);
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en) |-> $stable(rdata));
endmodule

bind uart_regbank uart_regbank_chk #(.DW(DW)) u_chk (.*);

// File: tb/test_uart_regbank.sv
module test_uart_regbank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, rx_data = '0, lsr_in = '0, msr_in = '0;
  logic       irq_pend = 1'b0;
  logic [2:0] irq_id = '0;
  logic [7:0] rdata, tx_data, lcr, div_lo, div_hi;
  logic       tx_push, rx_pop, rx_fifo_clr, tx_fifo_clr, fifo_en;
  logic [1:0] rx_trig;
  logic [3:0] ier;
  logic [4:0] mcr;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_d = 1'b0;
  logic       s_push, s_pop, s_rclr, s_tclr;
  logic [7:0] s_data;

  always #4 clk = ~clk;

  uart_regbank i_uart_regbank (.*);

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h exp %02h", tag, got, exp);
    end
  endtask

  always @(posedge clk) rd_d <= rd_en;

  always @(negedge clk) begin
    if (rd_d && exp_q.size() > 0) chk(tag_q.pop_front(), rdata, exp_q.pop_front());
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    s_push = tx_push; s_data = tx_data; s_rclr = rx_fifo_clr; s_tclr = tx_fifo_clr;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    s_pop = rx_pop;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: got 0 exp 1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 lcr", lcr, 8'h00);
    chk("R1 ier", {4'h0, ier}, 8'h00);
    chk("R1 mcr", {3'h0, mcr}, 8'h00);
    chk("R1 div", div_lo | div_hi, 8'h00);
    chk("R1 fifo", {5'h0, fifo_en, rx_trig}, 8'h00);
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 strobes", {4'h0, tx_push, rx_pop, rx_fifo_clr, tx_fifo_clr}, 8'h00);
    rd(3'd2, 8'h01, "R1 isr reset");

    // R10 reserved bits, R2 map
    wr(3'd1, 8'hFF); chk("R10 ier port", {4'h0, ier}, 8'h0F);
    rd(3'd1, 8'h0F, "R10 ier read");
    wr(3'd4, 8'hFF); rd(3'd4, 8'h1F, "R10 mcr read");
    wr(3'd7, 8'hA5); rd(3'd7, 8'hA5, "R2 spr");
    wr(3'd3, 8'h1B); rd(3'd3, 8'h1B, "R2 lcr");
    lsr_in = 8'h60; msr_in = 8'hB0;
    rd(3'd5, 8'h60, "R2 lsr");
    rd(3'd6, 8'hB0, "R2 msr");

    // R8 writes to status addresses
    wr(3'd5, 8'h33);
    chk("R8 strobes a5", {4'h0, s_push, 1'b0, s_rclr, s_tclr}, 8'h00);
    wr(3'd6, 8'h44);
    chk("R8 strobes a6", {4'h0, s_push, 1'b0, s_rclr, s_tclr}, 8'h00);
    rd(3'd5, 8'h60, "R8 lsr");
    rd(3'd6, 8'hB0, "R8 msr");
    rd(3'd1, 8'h0F, "R8 ier");
    rd(3'd3, 8'h1B, "R8 lcr");
    rd(3'd4, 8'h1F, "R8 mcr");
    rd(3'd7, 8'hA5, "R8 spr");
    chk("R8 div", div_lo | div_hi, 8'h00);
    chk("R8 fifo", {5'h0, fifo_en, rx_trig}, 8'h00);

    // R4 transmit push
    wr(3'd0, 8'h5A);
    chk("R4 push", {7'h0, s_push}, 8'h01);
    chk("R4 data", s_data, 8'h5A);
    @(negedge clk); chk("R4 push drop", {7'h0, tx_push}, 8'h00);

    // R5 receive pop
    rx_data = 8'hC3;
    rd(3'd0, 8'hC3, "R5 rhr");
    chk("R5 pop", {7'h0, s_pop}, 8'h01);
    @(negedge clk); chk("R5 pop drop", {7'h0, rx_pop}, 8'h00);

    // R6 FIFO control, R7 status word
    wr(3'd2, 8'hC7);
    chk("R6 clr pulses", {6'h0, s_rclr, s_tclr}, 8'h03);
    chk("R6 settings", {5'h0, fifo_en, rx_trig}, 8'h07);
    @(negedge clk); chk("R6 clr drop", {6'h0, rx_fifo_clr, tx_fifo_clr}, 8'h00);
    irq_pend = 1'b1; irq_id = 3'b110;
    rd(3'd2, 8'hCC, "R7 isr pend");
    wr(3'd2, 8'h41);
    chk("R6 no clr", {6'h0, s_rclr, s_tclr}, 8'h00);
    chk("R6 trig", {5'h0, fifo_en, rx_trig}, 8'h05);
    irq_pend = 1'b0; irq_id = 3'b000;
    rd(3'd2, 8'hC1, "R7 isr idle");

    // R3 divisor banking
    wr(3'd3, 8'h9B);
    wr(3'd0, 8'h34);
    chk("R3 no push", {7'h0, s_push}, 8'h00);
    chk("R3 div_lo", div_lo, 8'h34);
    wr(3'd1, 8'h12);
    chk("R3 div_hi", div_hi, 8'h12);
    chk("R3 ier kept", {4'h0, ier}, 8'h0F);
    rd(3'd0, 8'h34, "R3 read lo");
    chk("R3 no pop", {7'h0, s_pop}, 8'h00);
    rd(3'd1, 8'h12, "R3 read hi");

    // R9 line control and scratchpad under divisor access
    rd(3'd3, 8'h9B, "R9 lcr dlab");
    wr(3'd7, 8'h77); rd(3'd7, 8'h77, "R9 spr dlab");
    wr(3'd3, 8'h1B);
    rd(3'd1, 8'h0F, "R3 ier back");
    rd(3'd7, 8'h77, "R9 spr clear");

    // R11 read data hold
    lsr_in = 8'h21;
    rd(3'd5, 8'h21, "R11 read");
    lsr_in = 8'hFE; rx_data = 8'h99;
    repeat (4) @(negedge clk);
    chk("R11 hold", rdata, 8'h21);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule